// File: doc/BRIEF.md
# System Control Register File

This block is a bank of 32-bit system control words on a simple memory-mapped bus. The bus port has an address, a write enable with write data, and a read enable with read data. The block decodes a 4 KiB byte window. Only the lower 512 words of that window hold storage. Firmware reads identification words from it, which are loaded at reset, and keeps general-purpose scratch state in the rest.

Three of the identification words always read back with two status bits set. Those bits never enter storage. A write of a command value to a fixed offset in the unbacked upper part of the window sends a one-cycle reset-request or shutdown-request pulse to the system. Every access that misses the backed words raises a one-cycle error pulse. The block does not act on the requests itself.

All outputs are registered. Read data, the error pulse and the request pulses appear in the cycle after the access that causes them.

Top module: `sysctl_regfile`

## Requirements
- R1: After reset, word 0x40 (byte 0x100) holds 0x05F20121, word 0x41 (byte 0x104) holds 0x00000002, word 0x42 (byte 0x108) holds 0x05F30121 and word 0x43 (byte 0x10C) holds 0x05F40121. Every other word holds zero. While reset is held, all outputs are zero.
- R2: A write to a word index below 512 (byte address below 0x800) stores all 32 data bits. A later read of that word returns them.
- R3: Read data is registered. It is valid in the cycle after the read enable and is zero in any cycle that does not follow an accepted read.
- R4: A read of word 0x40, 0x42 or 0x43 returns the stored word OR 0x30000000. Storage keeps the written value, so bits that were written outside the mask read back as written. A read of word 0x41 is not forced.
- R5: The word index is the byte address shifted right by two. A byte address that is not word-aligned reaches the word that contains it, for both reads and writes.
- R6: A write with a word index of 512 or more changes no stored word, including word (index mod 512). In the next cycle the error output pulses for one cycle.
- R7: A read with a word index of 512 or more returns zero data. In the next cycle the error output pulses for one cycle.
- R8: A write to exact byte address 0xF00 with data 1 or 2 pulses the reset-request output in the next cycle. The error pulse also occurs, because the address is unbacked.
- R9: A write to exact byte address 0xF00 with data 3 pulses the shutdown-request output in the next cycle. Any other data value, and any other address, raises neither request.
- R10: The request outputs and the error output each stay high for one cycle per causing access. The two request outputs are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | 12 | Byte address inside the window |
| we_i | input | 1 | Write enable |
| wdata_i | input | 32 | Write data |
| re_i | input | 1 | Read enable |
| rdata_o | output | 32 | Read data, valid one cycle after re_i |
| err_o | output | 1 | One-cycle pulse for an access outside the backed words |
| rst_req_o | output | 1 | One-cycle system reset request |
| shdn_req_o | output | 1 | One-cycle system shutdown request |

## Verification
The assertions check the port-level timing rules on every cycle:
- a command write at 0xF00 always produces the matching request pulse one cycle later;
- the two request outputs are never high together;
- an out-of-range read always yields zero data with the error pulse;
- in-range accesses never raise the error pulse;
- idle cycles produce zero read data.

Other behaviour needs stored state observed across several accesses, so only the bench scenarios can show it:
- the identification values loaded at reset;
- full-width write-back;
- forcing the status bits without changing storage;
- unaligned addresses landing on the containing word;
- out-of-range writes leaving the aliased low word untouched.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    // Word indices whose reads carry the forced status bits
    localparam int unsigned FORCE_IDX_A = 'h40;
    localparam int unsigned FORCE_IDX_B = 'h42;
    localparam int unsigned FORCE_IDX_C = 'h43;
    localparam logic [31:0] FORCE_MASK  = 32'h3000_0000;

    // Command data values decoded at the command offset
    localparam logic [31:0] CMD_RESET_A = 32'd1;
    localparam logic [31:0] CMD_RESET_B = 32'd2;
    localparam logic [31:0] CMD_POWEROFF = 32'd3;

    // Reset value of a stored word, chosen by its word index
    function automatic logic [31:0] init_word(int unsigned idx);
        case (idx)
            'h40:    init_word = 32'h05F2_0121;
            'h41:    init_word = 32'h0000_0002;
            'h42:    init_word = 32'h05F3_0121;
            'h43:    init_word = 32'h05F4_0121;
            default: init_word = 32'h0000_0000;
        endcase
    endfunction

    // True when a word index belongs to the forced set
    function automatic logic is_forced(int unsigned idx);
        is_forced = (idx == FORCE_IDX_A) || (idx == FORCE_IDX_B) ||
                    (idx == FORCE_IDX_C);
    endfunction

endpackage

// File: rtl/sysctl_decode.sv
// Splits the word part of a bus address into a storage index, a
// range flag and the forced-status hit.
module sysctl_decode #(
    parameter int unsigned IDX_W     = 10,
    parameter int unsigned NUM_WORDS = 512,
    localparam int unsigned SIDX_W   = $clog2(NUM_WORDS)
) (
    input  logic [IDX_W-1:0]  word_addr_i,
    output logic [SIDX_W-1:0] store_idx_o,
    output logic              in_range_o,
    output logic              force_hit_o
);
    import sysctl_pkg::*;

    logic [IDX_W-1:0] full_idx;

    always_comb begin
        full_idx    = word_addr_i;
        in_range_o  = int'(full_idx) < int'(NUM_WORDS);
        store_idx_o = full_idx[SIDX_W-1:0];
        force_hit_o = in_range_o && is_forced(int'(full_idx));
    end

endmodule

// File: rtl/sysctl_store.sv
// Word storage: one write port, one combinational read port, reset
// values taken from the package.
module sysctl_store #(
    parameter int unsigned DATA_W    = 32,
    parameter int unsigned NUM_WORDS = 512,
    localparam int unsigned SIDX_W   = $clog2(NUM_WORDS)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [SIDX_W-1:0] idx_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic [DATA_W-1:0] rd_word_o
);
    import sysctl_pkg::*;

    logic [DATA_W-1:0] word_d [NUM_WORDS];
    logic [DATA_W-1:0] word_q [NUM_WORDS];

    always_comb begin
        for (int i = 0; i < int'(NUM_WORDS); i++) begin
            if (wr_en_i && (idx_i == SIDX_W'(i))) begin
                word_d[i] = wr_data_i;
            end else begin
                word_d[i] = word_q[i];
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            for (int i = 0; i < int'(NUM_WORDS); i++) begin
                word_q[i] <= DATA_W'(init_word(i));
            end
        end else begin
            word_q <= word_d;
        end
    end

    assign rd_word_o = word_q[idx_i];

endmodule

// File: rtl/sysctl_cmd.sv
// Decodes a write at the command offset into reset or shutdown hits.
module sysctl_cmd #(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned CMD_OFFSET = 'hF00
) (
    input  logic              we_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              rst_hit_o,
    output logic              shdn_hit_o
);
    import sysctl_pkg::*;

    logic at_cmd;

    always_comb begin
        at_cmd     = we_i && (addr_i == ADDR_W'(CMD_OFFSET));
        rst_hit_o  = at_cmd && ((wdata_i == DATA_W'(CMD_RESET_A)) ||
                                (wdata_i == DATA_W'(CMD_RESET_B)));
        shdn_hit_o = at_cmd && (wdata_i == DATA_W'(CMD_POWEROFF));
    end

endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile #(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned NUM_WORDS  = 512,
    parameter int unsigned CMD_OFFSET = 'hF00
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              re_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              err_o,
    output logic              rst_req_o,
    output logic              shdn_req_o
);
    import sysctl_pkg::*;

    localparam int unsigned IDX_W  = ADDR_W - 2;
    localparam int unsigned SIDX_W = $clog2(NUM_WORDS);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              err;
        logic              rst_req;
        logic              shdn_req;
    } out_regs_t;

    out_regs_t out_d, out_q;

    logic [SIDX_W-1:0] store_idx;
    logic              in_range;
    logic              force_hit;
    logic [DATA_W-1:0] rd_word;
    logic              rst_hit;
    logic              shdn_hit;

    sysctl_decode #(
        .IDX_W     (IDX_W),
        .NUM_WORDS (NUM_WORDS)
    ) i_decode (
        .word_addr_i (addr_i[ADDR_W-1:2]),
        .store_idx_o (store_idx),
        .in_range_o  (in_range),
        .force_hit_o (force_hit)
    );

    sysctl_store #(
        .DATA_W    (DATA_W),
        .NUM_WORDS (NUM_WORDS)
    ) i_store (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (we_i && in_range),
        .idx_i     (store_idx),
        .wr_data_i (wdata_i),
        .rd_word_o (rd_word)
    );

    sysctl_cmd #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .CMD_OFFSET (CMD_OFFSET)
    ) i_cmd (
        .we_i       (we_i),
        .addr_i     (addr_i),
        .wdata_i    (wdata_i),
        .rst_hit_o  (rst_hit),
        .shdn_hit_o (shdn_hit)
    );

    always_comb begin
        out_d          = '0;
        if (re_i && in_range) begin
            out_d.rdata = force_hit ? (rd_word | DATA_W'(FORCE_MASK)) : rd_word;
        end
        out_d.err      = (re_i || we_i) && !in_range;
        out_d.rst_req  = rst_hit;
        out_d.shdn_req = shdn_hit;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign rdata_o    = out_q.rdata;
    assign err_o      = out_q.err;
    assign rst_req_o  = out_q.rst_req;
    assign shdn_req_o = out_q.shdn_req;

endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk #(
    parameter int unsigned ADDR_W     = 12,
    parameter int unsigned DATA_W     = 32,
    parameter int unsigned NUM_WORDS  = 512,
    parameter int unsigned CMD_OFFSET = 'hF00
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] addr_i,
    input logic              we_i,
    input logic [DATA_W-1:0] wdata_i,
    input logic              re_i,
    input logic [DATA_W-1:0] rdata_o,
    input logic              err_o,
    input logic              rst_req_o,
    input logic              shdn_req_o
);
    logic hit_range;
    logic at_cmd;
    assign hit_range = int'(addr_i >> 2) < int'(NUM_WORDS);
    assign at_cmd    = we_i && (addr_i == ADDR_W'(CMD_OFFSET));

    p_cmd_reset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        at_cmd && ((wdata_i == DATA_W'(1)) || (wdata_i == DATA_W'(2)))
        |=> rst_req_o && err_o);

    p_cmd_shdn_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        at_cmd && (wdata_i == DATA_W'(3)) |=> shdn_req_o && !rst_req_o);

    p_no_request_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !at_cmd |=> !rst_req_o && !shdn_req_o);

    p_req_exclusive_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(rst_req_o && shdn_req_o));

    p_bad_read_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        re_i && !hit_range |=> err_o && (rdata_o == '0));

    p_good_access_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (re_i || we_i) && hit_range |=> !err_o);

    p_idle_read_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !re_i |=> rdata_o == '0);

endmodule

bind sysctl_regfile sysctl_regfile_chk #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .NUM_WORDS  (NUM_WORDS),
    .CMD_OFFSET (CMD_OFFSET)
) i_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .we_i       (we_i),
    .wdata_i    (wdata_i),
    .re_i       (re_i),
    .rdata_o    (rdata_o),
    .err_o      (err_o),
    .rst_req_o  (rst_req_o),
    .shdn_req_o (shdn_req_o)
);

// File: tb/test_sysctl_regfile.sv
module test_sysctl_regfile;

    localparam int CLK_PERIOD = 10;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [11:0] addr_i = '0;
    logic        we_i = 1'b0;
    logic [31:0] wdata_i = '0;
    logic        re_i = 1'b0;
    logic [31:0] rdata_o;
    logic        err_o;
    logic        rst_req_o;
    logic        shdn_req_o;

    int compared = 0;
    int mismatched = 0;

    always #(CLK_PERIOD / 2) clk_i = ~clk_i;

    sysctl_regfile i_sysctl_regfile (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .addr_i     (addr_i),
        .we_i       (we_i),
        .wdata_i    (wdata_i),
        .re_i       (re_i),
        .rdata_o    (rdata_o),
        .err_o      (err_o),
        .rst_req_o  (rst_req_o),
        .shdn_req_o (shdn_req_o)
    );

    typedef struct packed {
        logic        we;
        logic        re;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp_rd;
        logic        exp_err;
        logic        exp_rst;
        logic        exp_shdn;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 23;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 1'b1, 12'h100, 32'h0,        32'h35F2_0121, 1'b0, 1'b0, 1'b0, 8'd4},  // R4 on id word
        '{1'b0, 1'b1, 12'h104, 32'h0,        32'h0000_0002, 1'b0, 1'b0, 1'b0, 8'd1},  // R1 unforced
        '{1'b0, 1'b1, 12'h108, 32'h0,        32'h35F3_0121, 1'b0, 1'b0, 1'b0, 8'd4},
        '{1'b0, 1'b1, 12'h10C, 32'h0,        32'h35F4_0121, 1'b0, 1'b0, 1'b0, 8'd4},
        '{1'b0, 1'b1, 12'h000, 32'h0,        32'h0,         1'b0, 1'b0, 1'b0, 8'd1},  // R1 zero word
        '{1'b1, 1'b0, 12'h010, 32'hDEADBEEF, 32'h0,         1'b0, 1'b0, 1'b0, 8'd2},  // R2 write
        '{1'b0, 1'b1, 12'h010, 32'h0,        32'hDEADBEEF,  1'b0, 1'b0, 1'b0, 8'd2},
        '{1'b0, 1'b1, 12'h013, 32'h0,        32'hDEADBEEF,  1'b0, 1'b0, 1'b0, 8'd5},  // R5 unaligned read
        '{1'b1, 1'b0, 12'h101, 32'h0000_0005, 32'h0,        1'b0, 1'b0, 1'b0, 8'd5},  // R5 unaligned write
        '{1'b0, 1'b1, 12'h100, 32'h0,        32'h3000_0005, 1'b0, 1'b0, 1'b0, 8'd4},
        '{1'b1, 1'b0, 12'h7FC, 32'hA5A5A5A5, 32'h0,         1'b0, 1'b0, 1'b0, 8'd2},  // last word
        '{1'b0, 1'b1, 12'h7FC, 32'h0,        32'hA5A5A5A5,  1'b0, 1'b0, 1'b0, 8'd2},
        '{1'b1, 1'b0, 12'h800, 32'h11111111, 32'h0,         1'b1, 1'b0, 1'b0, 8'd6},  // R6 bad write
        '{1'b0, 1'b1, 12'h000, 32'h0,        32'h0,         1'b0, 1'b0, 1'b0, 8'd6},  // no alias
        '{1'b0, 1'b1, 12'h800, 32'h0,        32'h0,         1'b1, 1'b0, 1'b0, 8'd7},  // R7 bad read
        '{1'b0, 1'b1, 12'hFFC, 32'h0,        32'h0,         1'b1, 1'b0, 1'b0, 8'd7},
        '{1'b1, 1'b0, 12'hF00, 32'd1,        32'h0,         1'b1, 1'b1, 1'b0, 8'd8},  // R8
        '{1'b1, 1'b0, 12'hF00, 32'd2,        32'h0,         1'b1, 1'b1, 1'b0, 8'd8},
        '{1'b1, 1'b0, 12'hF00, 32'd3,        32'h0,         1'b1, 1'b0, 1'b1, 8'd9},  // R9
        '{1'b1, 1'b0, 12'hF00, 32'd4,        32'h0,         1'b1, 1'b0, 1'b0, 8'd9},
        '{1'b1, 1'b0, 12'hF00, 32'd0,        32'h0,         1'b1, 1'b0, 1'b0, 8'd9},
        '{1'b1, 1'b0, 12'hF04, 32'd1,        32'h0,         1'b1, 1'b0, 1'b0, 8'd9},
        '{1'b0, 1'b0, 12'h000, 32'h0,        32'h0,         1'b0, 1'b0, 1'b0, 8'd10}  // R10 pulse ends
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic check_outs(input string tag, input logic [31:0] erd, input logic eerr,
                              input logic erst, input logic eshdn);
        check({tag, " rdata"}, rdata_o, erd);
        check({tag, " err"}, {31'b0, err_o}, {31'b0, eerr});
        check({tag, " rst_req"}, {31'b0, rst_req_o}, {31'b0, erst});
        check({tag, " shdn_req"}, {31'b0, shdn_req_o}, {31'b0, eshdn});
    endtask

    // Drive one access at the falling edge, sample registered outputs after the next rise
    task automatic access(input logic w, input logic r, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk_i);
        we_i = w; re_i = r; addr_i = a; wdata_i = d;
        @(posedge clk_i);
        #(CLK_PERIOD / 4);
        @(negedge clk_i);
        we_i = 1'b0; re_i = 1'b0;
        #0;
    endtask

    task automatic op(input logic w, input logic r, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk_i);
        we_i = w; re_i = r; addr_i = a; wdata_i = d;
        @(posedge clk_i);
        #(CLK_PERIOD / 4);
    endtask

    initial begin
        repeat (20000) @(posedge clk_i);
        compared++;
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk_i);
        #(CLK_PERIOD / 4);
        check_outs("R1 outputs in reset", 32'h0, 1'b0, 1'b0, 1'b0);
        @(negedge clk_i);
        rst_ni = 1'b1;

        for (int k = 0; k < NVEC; k++) begin
            op(VECS[k].we, VECS[k].re, VECS[k].addr, VECS[k].wdata);
            check_outs($sformatf("R%0d vec %0d", VECS[k].req, k),
                       VECS[k].exp_rd, VECS[k].exp_err, VECS[k].exp_rst, VECS[k].exp_shdn);
        end

        // R10: a single command write yields a single-cycle pulse
        op(1'b1, 1'b0, 12'hF00, 32'd1);
        check("R10 rst pulse high", {31'b0, rst_req_o}, 32'd1);
        op(1'b0, 1'b0, 12'h000, 32'd0);
        check("R10 rst pulse low", {31'b0, rst_req_o}, 32'd0);
        check("R10 err pulse low", {31'b0, err_o}, 32'd0);

        // R2: full-width write on the unforced id word
        op(1'b1, 1'b0, 12'h104, 32'hFFFF_FFFF);
        op(1'b0, 1'b1, 12'h104, 32'd0);
        check("R2 full width", rdata_o, 32'hFFFF_FFFF);

        // R4: written bits outside the mask survive, mask bits still forced
        op(1'b1, 1'b0, 12'h108, 32'h0000_0000);
        op(1'b0, 1'b1, 12'h108, 32'd0);
        check("R4 forced over zero", rdata_o, 32'h3000_0000);

        // R3: read data cleared on the idle cycle after a read
        op(1'b0, 1'b0, 12'h108, 32'd0);
        check("R3 idle rdata", rdata_o, 32'h0);

        // R1: reset reloads id words and clears scratch words
        @(negedge clk_i);
        rst_ni = 1'b0;
        repeat (2) @(posedge clk_i);
        @(negedge clk_i);
        rst_ni = 1'b1;
        op(1'b0, 1'b1, 12'h104, 32'd0);
        check("R1 reload word 0x41", rdata_o, 32'h0000_0002);
        op(1'b0, 1'b1, 12'h010, 32'd0);
        check("R1 scratch cleared", rdata_o, 32'h0);
        op(1'b0, 1'b1, 12'h108, 32'd0);
        check("R1 reload word 0x42", rdata_o, 32'h35F3_0121);
        op(1'b0, 1'b0, 12'h000, 32'd0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule